// File: doc/BRIEF.md
# Timer-Clocked Three-Wire Serial Shifter

This block moves one byte at a time over a three-wire serial link made of a clock line, an outgoing data line and an incoming data line. A single data shift register serves both directions: the outgoing bit is its top bit, and each sampled incoming bit enters at the bottom. An edge counter counts every clock transition, both rising and falling. When it wraps after sixteen transitions, the byte is complete. The shifted byte is then copied into a receive buffer and a completion flag is raised.

As master, the block drives the clock line itself. A compare timer fed by a selectable prescaler toggles the line on every match, so one bit period spans two matches. Toggling begins with an accepted write and stops on its own once the byte is complete. As slave, the clock line is an input that is brought into the system clock domain. A write then only preloads the byte for the next transfer the remote master starts. In both modes, a write that arrives while the edge counter is not at zero is refused and raises a collision flag.

Top module: `ser3w_shifter`

## Requirements
- R1: After reset, the completion flag, the collision flag and the receive buffer are all zero, and in master mode the clock line rests at the level of the polarity input.
- R2: In master mode, consecutive clock-line toggles are exactly div*(cmp_val+1) system cycles apart. The divider div is 1, 8, 64, 256 or 1024 for psc_sel codes 0, 1, 2, 3 and 4, and any code above 4 also selects 1024.
- R3: A master transfer makes exactly 16 toggles and then stops with the line back at its idle level. The completion flag rises in the same cycle as the sixteenth edge.
- R4: Data leaves most significant bit first. The current bit is on sdo at every sampling edge, and bits taken from sdi fill the byte from the least significant end. After completion, rx_data holds the received byte.
- R5: The receive buffer changes only when a transfer completes, so an accepted write does not alter it.
- R6: A write while the edge counter is non-zero sets the collision flag and leaves the byte being shifted untouched.
- R7: An accepted write (counter at zero) clears both flags and loads the byte.
- R8: In slave mode the clock line is not driven (sck_oe low), and a write only preloads data. Sixteen external clock edges complete the byte.
- R9: With polarity 0 the sampling edge is rising and the shifting edge falling. With polarity 1 these are reversed, and the master clock line idles at the polarity level.
- R10: A one-cycle init pulse clears both flags and the receive buffer and stops any transfer.
- R11: A refused write in the same cycle as the sixteenth edge sets both the collision flag and the completion flag, and the received byte is still stored intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = master (drives the clock), 0 = slave |
| cfg_pol | input | 1 | Sampling edge polarity and master idle level |
| cfg_init | input | 1 | One-cycle pulse that reinitialises flags and the buffer |
| psc_sel | input | 3 | Prescaler code |
| cmp_val | input | 8 | Timer compare value |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Buffered received byte |
| done_flag | output | 1 | Transfer complete |
| coll_flag | output | 1 | Write collision |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock from a remote master |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The overlap that matters is between a refused write and byte completion. When the write strobe meets the sixteenth clock edge, the counter still reads fifteen, so the write must collide while the wrap is latching the received byte. The bench measures the interval between toggles on the live clock line. It raises the write strobe in the system cycle just before the predicted final toggle. It then expects both flags set, the received byte intact and the line back at idle. Mid-transfer collisions are also provoked, and the transmitted bit stream is judged against the original byte.

// File: rtl/ser3w_pkg.sv
// Shared constants and helpers for the three-wire shifter.
// Assumes prescaler codes 0..4 map to power-of-eight-ish dividers; larger codes saturate.
package ser3w_pkg;
    localparam int PSC_W = 11;  // wide enough to hold the largest divider, 1024

    // Divider selected by a prescaler code.
    function automatic logic [PSC_W-1:0] psc_div(input logic [2:0] sel);
        case (sel)
            3'd0:    psc_div = 11'd1;
            3'd1:    psc_div = 11'd8;
            3'd2:    psc_div = 11'd64;
            3'd3:    psc_div = 11'd256;
            default: psc_div = 11'd1024;
        endcase
    endfunction
endpackage

// File: rtl/ser3w_timer.sv
// Prescaled compare timer with clear-on-match.
// Raises a one-cycle match pulse every div*(cmp+1) system cycles while enabled.
// Assumes clr and !en put it back to count zero, which drops any pending match.
module ser3w_timer #(
    parameter int CMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [2:0]       psc_sel,
    input  logic [CMP_W-1:0] cmp_val,
    output logic             match
);
    import ser3w_pkg::*;

    logic [PSC_W-1:0] pcnt_q;
    logic [CMP_W-1:0] tcnt_q;
    logic [PSC_W-1:0] div;
    logic             ptick;

    assign div   = psc_div(psc_sel);
    assign ptick = en && (pcnt_q == div - 1'b1);
    assign match = ptick && (tcnt_q == cmp_val);

    // Prescaler and compare counters, both cleared when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            pcnt_q <= '0;
            tcnt_q <= '0;
        end else begin
            pcnt_q <= ptick ? '0 : pcnt_q + 1'b1;
            if (ptick) tcnt_q <= match ? '0 : tcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ser3w_clkgen.sv
// Serial clock source and edge classifier.
// Master: toggles its own line on each timer match while a transfer runs; idles at pol.
// Slave: synchronises the external clock and data through two flops and finds edges.
// An edge is a sampling (leading) edge when the line moves away from the pol level.
module ser3w_clkgen (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic pol,
    input  logic init,
    input  logic run,
    input  logic match,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sck_o,
    output logic edge_evt,
    output logic lead_evt,
    output logic sdi_smp
);
    logic       sck_q;
    logic [2:0] sck_sync_q;
    logic [1:0] sdi_sync_q;
    logic       m_edge, s_edge, new_lvl;

    // Master clock line: rests at pol, flips on each match during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || init || !run) sck_q <= pol;
        else if (match)             sck_q <= ~sck_q;
    end

    // Two-flop synchronisers for the remote clock and incoming data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sync_q <= '0;
            sdi_sync_q <= '0;
        end else begin
            sck_sync_q <= {sck_sync_q[1:0], sck_i};
            sdi_sync_q <= {sdi_sync_q[0], sdi_i};
        end
    end

    assign m_edge   = run && match;
    assign s_edge   = sck_sync_q[1] ^ sck_sync_q[2];
    assign edge_evt = master ? m_edge : s_edge;
    assign new_lvl  = master ? ~sck_q : sck_sync_q[1];
    assign lead_evt = edge_evt && (new_lvl != pol);
    assign sdi_smp  = master ? sdi_i : sdi_sync_q[1];
    assign sck_o    = sck_q;
endmodule

// File: rtl/ser3w_shift.sv
// Data shift register, both-edge counter, flags and receive buffer.
// Sampling edges capture one input bit; shifting edges move it in at the LSB.
// Assumes edge_evt/lead_evt are single-cycle pulses from the clock source.
module ser3w_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic          init,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          edge_evt,
    input  logic          lead_evt,
    input  logic          sdi_smp,
    output logic          sdo,
    output logic          run,
    output logic          load,
    output logic [DW-1:0] rx_data,
    output logic          done,
    output logic          coll
);
    localparam int EDGES = 2 * DW;
    localparam int CW    = $clog2(EDGES);

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] sh_q, rx_q, sh_next;
    logic          smp_q, done_q, coll_q, run_q;
    logic          busy, collide, wrap;

    assign busy    = (cnt_q != '0);
    assign load    = wr_en && !busy && !init;
    assign collide = wr_en && busy && !init;
    assign wrap    = edge_evt && !load && (cnt_q == CW'(EDGES - 1));
    assign sh_next = {sh_q[DW-2:0], smp_q};

    // Transfer state: load, sample/shift per edge, latch result on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            smp_q  <= 1'b0;
            rx_q   <= '0;
            done_q <= 1'b0;
            coll_q <= 1'b0;
            run_q  <= 1'b0;
        end else if (load) begin
            sh_q   <= wr_data;
            cnt_q  <= '0;
            done_q <= 1'b0;
            coll_q <= 1'b0;
            run_q  <= master;
        end else begin
            if (collide) coll_q <= 1'b1;
            if (edge_evt) begin
                cnt_q <= cnt_q + 1'b1;
                if (lead_evt) smp_q <= sdi_smp;
                else          sh_q  <= sh_next;
            end
            if (wrap) begin
                done_q <= 1'b1;
                rx_q   <= sh_next;
                run_q  <= 1'b0;
            end
        end
    end

    assign sdo     = sh_q[DW-1];
    assign run     = run_q;
    assign rx_data = rx_q;
    assign done    = done_q;
    assign coll    = coll_q;

    // Refused write must leave the collision flag raised.
    p_coll_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> coll_q);
    // Accepted write clears both flags.
    p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!done_q && !coll_q));
    // Receive buffer moves only on completion or init.
    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !init) |=> $stable(rx_q));
    // Completion stops the master clock and raises the flag.
    p_wrap_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (!run_q && done_q));
    // Collision and completion in one cycle keep both flags.
    p_both_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && collide) |=> (done_q && coll_q));
endmodule

// File: rtl/ser3w_shifter.sv
// Top of the timer-clocked three-wire serial shifter.
// Wires the compare timer, the clock source and the shift core together.
// Assumes mode and polarity change only while no transfer is in progress.
module ser3w_shifter #(
    parameter int DW    = 8,
    parameter int CMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic             cfg_pol,
    input  logic             cfg_init,
    input  logic [2:0]       psc_sel,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rx_data,
    output logic             done_flag,
    output logic             coll_flag,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             sck_i,
    output logic             sdo,
    input  logic             sdi
);
    logic run, load, match, edge_evt, lead_evt, sdi_smp;

    ser3w_timer #(.CMP_W(CMP_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(run && cfg_master), .clr(load),
        .psc_sel(psc_sel), .cmp_val(cmp_val), .match(match)
    );

    ser3w_clkgen u_clk (
        .clk(clk), .rst_n(rst_n), .master(cfg_master), .pol(cfg_pol),
        .init(cfg_init), .run(run), .match(match), .sck_i(sck_i), .sdi_i(sdi),
        .sck_o(sck_o), .edge_evt(edge_evt), .lead_evt(lead_evt), .sdi_smp(sdi_smp)
    );

    ser3w_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .master(cfg_master), .init(cfg_init),
        .wr_en(wr_en), .wr_data(wr_data), .edge_evt(edge_evt), .lead_evt(lead_evt),
        .sdi_smp(sdi_smp), .sdo(sdo), .run(run), .load(load), .rx_data(rx_data),
        .done(done_flag), .coll(coll_flag)
    );

    assign sck_oe = cfg_master;
endmodule

// File: tb/ser3w_shifter_tb.sv
module ser3w_shifter_tb;
    localparam int CLK_P = 10;
    localparam int HALF  = 6;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cfg_master = 1'b1, cfg_pol = 1'b0, cfg_init = 1'b0;
    logic [2:0] psc_sel = 3'd0;
    logic [7:0] cmp_val = 8'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rx_data;
    logic       done_flag, coll_flag, sck_o, sck_oe, sdo;
    logic       sck_i = 1'b0, sdi = 1'b0;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    ser3w_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_pol(cfg_pol),
        .cfg_init(cfg_init), .psc_sel(psc_sel), .cmp_val(cmp_val), .wr_en(wr_en),
        .wr_data(wr_data), .rx_data(rx_data), .done_flag(done_flag),
        .coll_flag(coll_flag), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
        .sdo(sdo), .sdi(sdi)
    );

    function automatic int exp_div(input logic [2:0] sel);
        case (sel)
            3'd0: return 1;
            3'd1: return 8;
            3'd2: return 64;
            3'd3: return 256;
            default: return 1024;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_init();
        @(negedge clk) cfg_init = 1'b1;
        @(negedge clk) cfg_init = 1'b0;
    endtask

    // Master transfer. bench acts as remote slave. coll_at: 0 none, 1..15 write after that
    // toggle, 99 write in the cycle of the final toggle.
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rxb,
                               input logic [2:0] sel, input logic [7:0] cmp,
                               input logic pol, input int coll_at);
        int per, nchg, since, guard;
        logic prev;
        logic [7:0] old_rx;
        bit per_ok, sdo_ok;
        per = exp_div(sel) * (int'(cmp) + 1);
        cfg_master = 1'b1; cfg_pol = pol; psc_sel = sel; cmp_val = cmp;
        repeat (3) @(negedge clk);
        old_rx = rx_data;
        sdi = rxb[7];
        wr_data = tx; wr_en = 1'b1;
        @(negedge clk) wr_en = 1'b0;
        chk(!done_flag && !coll_flag, "R7 flags cleared by write", {done_flag, coll_flag}, 0);
        chk(rx_data == old_rx, "R5 rx kept on write", rx_data, old_rx);
        prev = sck_o; nchg = 0; since = 0; per_ok = 1; sdo_ok = 1; guard = 0;
        while (nchg < 16 && guard < 40000) begin
            @(negedge clk);
            guard++;
            if (wr_en) wr_en = 1'b0;
            since++;
            if (sck_o != prev) begin
                nchg++;
                if (nchg > 1 && since != per) per_ok = 0;
                since = 0;
                prev = sck_o;
                if (sck_o != pol) begin
                    if (sdo != tx[7 - (nchg - 1) / 2]) sdo_ok = 0;
                end else if (nchg < 16) begin
                    sdi = rxb[7 - nchg / 2];
                end
                if (coll_at == nchg && nchg < 16) begin
                    wr_data = ~tx; wr_en = 1'b1;
                end
            end
            if (wr_en == 1'b0 && coll_at == 99 && nchg == 15 && since == per - 1) begin
                wr_data = ~tx; wr_en = 1'b1;
            end
        end
        wr_en = 1'b0;
        chk(nchg == 16, "R3 sixteen toggles", nchg, 16);
        chk(per_ok, "R2 toggle spacing", per_ok, per);
        chk(sdo_ok, "R4/R6 msb-first sdo", tx, tx);
        chk(done_flag, "R3 done at final edge", done_flag, 1);
        chk(rx_data == rxb, "R4 received byte", rx_data, rxb);
        chk(coll_flag == (coll_at != 0), "R6/R11 collision flag", coll_flag, coll_at != 0);
        repeat (2 * per + 2) @(negedge clk);
        chk(sck_o == pol && sck_oe, "R9 idle level after stop", sck_o, pol);
        chk(rx_data == rxb, "R3 no further edges", rx_data, rxb);
    endtask

    // Slave transfer; bench acts as remote master with a half period of HALF cycles.
    task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] rxb, input logic pol);
        bit sdo_ok;
        cfg_master = 1'b0; cfg_pol = pol; sck_i = pol;
        repeat (5) @(negedge clk);
        pulse_init();
        wr_data = tx; wr_en = 1'b1;
        @(negedge clk) wr_en = 1'b0;
        repeat (20) @(negedge clk);
        chk(!done_flag && !sck_oe && rx_data == 8'h00, "R8 preload only", done_flag, 0);
        sdo_ok = 1;
        for (int k = 0; k < 8; k++) begin
            sdi = rxb[7 - k];
            repeat (HALF) @(negedge clk);
            if (sdo != tx[7 - k]) sdo_ok = 0;
            sck_i = ~pol;
            repeat (HALF) @(negedge clk);
            sck_i = pol;
        end
        repeat (HALF) @(negedge clk);
        chk(sdo_ok, "R8/R4 slave sdo msb first", tx, tx);
        chk(done_flag && !coll_flag, "R8 slave done", done_flag, 1);
        chk(rx_data == rxb, "R8/R9 slave received byte", rx_data, rxb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!done_flag && !coll_flag, "R1 flags at reset", {done_flag, coll_flag}, 0);
        chk(rx_data == 8'h00, "R1 rx at reset", rx_data, 0);
        chk(sck_o == 1'b0 && sck_oe, "R1 idle clock", sck_o, 0);

        // Directed: divider codes and polarity
        master_xfer(8'hA5, 8'h3C, 3'd0, 8'd0, 1'b0, 0);
        master_xfer(8'h81, 8'hE7, 3'd1, 8'd3, 1'b1, 0);
        master_xfer(8'h5A, 8'h01, 3'd3, 8'd1, 1'b0, 0);
        master_xfer(8'hFF, 8'h80, 3'd4, 8'd0, 1'b1, 0);
        master_xfer(8'h12, 8'h34, 3'd6, 8'd0, 1'b0, 0);
        // R6 collision mid-transfer, R11 collision at final edge
        master_xfer(8'hC3, 8'h96, 3'd1, 8'd1, 1'b0, 5);
        master_xfer(8'h3E, 8'h7B, 3'd0, 8'd2, 1'b1, 99);
        master_xfer(8'h6D, 8'hD2, 3'd0, 8'd0, 1'b0, 99);
        // R10 init clears
        pulse_init();
        @(negedge clk);
        chk(!done_flag && !coll_flag && rx_data == 8'h00, "R10 init clears",
            rx_data, 0);

        // Random master transfers
        for (int i = 0; i < 20; i++) begin
            master_xfer(8'($urandom), 8'($urandom), 3'($urandom_range(0, 1)),
                        8'($urandom_range(0, 3)), 1'($urandom), 0);
        end
        // Slave transfers: directed then random
        slave_xfer(8'hB4, 8'h2D, 1'b0);
        slave_xfer(8'h0F, 8'hF1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            slave_xfer(8'($urandom), 8'($urandom), 1'($urandom));
        end
        // Back to master after slave operation
        master_xfer(8'h99, 8'h66, 3'd0, 8'd1, 1'b0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule